// File: doc/BRIEF.md
# Injection Throttle Controller for a Bufferless Mesh

This block sits beside a bufferless on-chip network and decides, once per fixed-length interval, whether the cores' injection must be slowed. For each core it counts three kinds of event. A starved cycle is a cycle where the core has a flit ready but no output port is free. It also counts retired instructions and flits that were actually injected. Congestion is judged from starvation rate alone. Network latency plays no part.

At each interval boundary every core's starved count is compared with a programmable fraction of the interval length. This uses a shift and a multiply, so no divider is needed. If any core is over the limit, the network is congested. Each core's instructions-per-flit is then compared with the aggregate ratio of the whole chip by cross-multiplication. Cores that extract little work from their traffic receive a throttle rate, and a core that is further below the aggregate receives a larger one.

A per-core gate applies the rate. In each 16-cycle window it blocks injection for as many cycles as the rate says. The settings stay fixed for a whole interval.

Top module: `inj_throttle_ctrl`

## Requirements
- R1: `congested` reads 1 during an interval exactly when, in the previous interval, some core had `s * 2^FRAC_K > thr * INTERVAL`. Here `s` is that core's starved-cycle count, meaning cycles with `flit_ready=1` and `port_free=0`. `thr` is `cfg_starve_thr`. The comparison is strict.
- R2: `rate_out` and `congested` change only on the clock edge that ends an interval. Their new values govern injection from the first cycle of the next interval. The interval timer starts at cycle 0 after reset and an interval lasts INTERVAL cycles.
- R3: After an interval with no congestion, every core's rate is 0, and a nonzero rate is never shown while `congested` is 0.
- R4: Under congestion, a core with `2*I*Ft < It*F` gets rate `cfg_rate`. `I` and `F` are the core's own instruction and injected-flit counts. `It` and `Ft` are the totals over all cores.
- R5: Under congestion, a core with `I*Ft < It*F` that does not meet the R4 test gets rate `cfg_rate >> 1`. A core with `I*Ft >= It*F` gets 0.
- R6: A core that injected no flit in the interval gets rate 0 regardless of congestion.
- R7: Core i's rate is field `rate_out[4*i+3:4*i]`. A per-core 4-bit phase counts 0..15 from the first cycle after reset and wraps. `inj_grant[i] = flit_ready[i] & port_free[i]` except in cycles where the phase is below the core's rate, when it is 0.
- R8: All event counters restart from zero at each interval boundary, so a decision uses only events of its own interval.
- R9: While `rst_n` is low, `rate_out` is 0 and `congested` is 0.
- R10: An injected flit is a cycle with `inj_grant=1`. An instruction is a cycle with `instr_ret=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_starve_thr | input | FRAC_K+1 | Starvation limit in units of 1/2^FRAC_K of the interval |
| cfg_rate | input | 4 | Full throttle rate for low-yield cores |
| flit_ready | input | N_CORES | Core has a flit waiting to inject |
| port_free | input | N_CORES | Router has a free output port for that core |
| instr_ret | input | N_CORES | Core retired an instruction this cycle |
| inj_grant | output | N_CORES | Injection allowed and taken this cycle |
| rate_out | output | 4*N_CORES | Active throttle rate per core |
| congested | output | 1 | Last interval was judged congested |

## Verification
The bench builds the block with 4 cores, a 64-cycle interval and FRAC_K=6. With these values about seven full decisions fit in a few hundred cycles. A threshold step of 1/64 then equals exactly one starved cycle. This lets the bench drive a core to exactly the threshold count and to one cycle above it, which exercises the strict comparison. Several intervals run under heavy starvation with uneven retire rates and one silent core. This puts cores on both rate tiers, at zero, and in the idle case. The gates then run with nonzero rates.

// File: rtl/inj_thr_pkg.sv
`timescale 1ns/1ps
package inj_thr_pkg;
  localparam int RATE_W  = 4;
  localparam int PHASE_W = 4;
  typedef logic [RATE_W-1:0] rate_t;

  // Gate closes while the free-running phase is below the rate.
  function automatic logic gate_blocks(input logic [PHASE_W-1:0] phase, input rate_t rate);
    return phase < rate;
  endfunction
endpackage

// File: rtl/inj_thr_cnt.sv
`timescale 1ns/1ps
module inj_thr_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             starve_ev,
  input  logic             instr_ev,
  input  logic             flit_ev,
  output logic [CNT_W-1:0] starve_q,
  output logic [CNT_W-1:0] instr_q,
  output logic [CNT_W-1:0] flit_q,
  output logic [CNT_W-1:0] starve_nxt,
  output logic [CNT_W-1:0] instr_nxt,
  output logic [CNT_W-1:0] flit_nxt
);
  // Counts including the current cycle; the decision sees these on the last cycle.
  assign starve_nxt = starve_q + CNT_W'(starve_ev);
  assign instr_nxt  = instr_q  + CNT_W'(instr_ev);
  assign flit_nxt   = flit_q   + CNT_W'(flit_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      starve_q <= '0;
      instr_q  <= '0;
      flit_q   <= '0;
    end else if (clear) begin
      starve_q <= '0;
      instr_q  <= '0;
      flit_q   <= '0;
    end else begin
      starve_q <= starve_nxt;
      instr_q  <= instr_nxt;
      flit_q   <= flit_nxt;
    end
  end
endmodule

// File: rtl/inj_thr_decide.sv
`timescale 1ns/1ps
module inj_thr_decide import inj_thr_pkg::*; #(
  parameter int N_CORES  = 4,
  parameter int CNT_W    = 17,
  parameter int TOT_W    = 19,
  parameter int FRAC_K   = 8,
  parameter int INTERVAL = 100000
) (
  input  logic [N_CORES*CNT_W-1:0]  starve,
  input  logic [N_CORES*CNT_W-1:0]  instr,
  input  logic [N_CORES*CNT_W-1:0]  flits,
  input  logic [FRAC_K:0]           thr,
  input  rate_t                     cfg_rate,
  output logic                      cong,
  output logic [N_CORES*RATE_W-1:0] rate_new
);
  localparam int LIM_W  = FRAC_K + 1 + CNT_W + 1;
  localparam int PROD_W = CNT_W + TOT_W + 1;

  // starved * 2^K > thr * INTERVAL, no divider.
  function automatic logic over_limit(input logic [CNT_W-1:0] s, input logic [FRAC_K:0] t);
    logic [LIM_W-1:0] lhs, rhs;
    lhs = LIM_W'(s) << FRAC_K;
    rhs = LIM_W'(t) * LIM_W'(INTERVAL);
    return lhs > rhs;
  endfunction

  // Own IPF against aggregate IPF by cross-multiplication.
  function automatic rate_t pick_rate(input logic [CNT_W-1:0] i_own, input logic [CNT_W-1:0] f_own,
                                      input logic [TOT_W-1:0] i_tot, input logic [TOT_W-1:0] f_tot,
                                      input rate_t full);
    logic [PROD_W-1:0] own, avg;
    own = PROD_W'(i_own) * PROD_W'(f_tot);
    avg = PROD_W'(i_tot) * PROD_W'(f_own);
    if (f_own == '0)            return '0;
    else if ((own << 1) < avg)  return full;
    else if (own < avg)         return full >> 1;
    else                        return '0;
  endfunction

  logic [TOT_W-1:0] i_sum, f_sum;

  always_comb begin
    i_sum = '0;
    f_sum = '0;
    cong  = 1'b0;
    for (int i = 0; i < N_CORES; i++) begin
      i_sum = i_sum + TOT_W'(instr[i*CNT_W +: CNT_W]);
      f_sum = f_sum + TOT_W'(flits[i*CNT_W +: CNT_W]);
      cong  = cong | over_limit(starve[i*CNT_W +: CNT_W], thr);
    end
    rate_new = '0;
    for (int i = 0; i < N_CORES; i++) begin
      if (cong)
        rate_new[i*RATE_W +: RATE_W] = pick_rate(instr[i*CNT_W +: CNT_W], flits[i*CNT_W +: CNT_W],
                                                 i_sum, f_sum, cfg_rate);
    end
  end
endmodule

// File: rtl/inj_thr_gate.sv
`timescale 1ns/1ps
module inj_thr_gate import inj_thr_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_t rate,
  input  logic  ready,
  input  logic  free,
  output logic  grant
);
  logic [PHASE_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  assign grant = ready & free & ~gate_blocks(phase, rate);
endmodule

// File: rtl/inj_throttle_ctrl.sv
`timescale 1ns/1ps
module inj_throttle_ctrl import inj_thr_pkg::*; #(
  parameter int N_CORES  = 4,
  parameter int INTERVAL = 100000,
  parameter int FRAC_K   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [FRAC_K:0]           cfg_starve_thr,
  input  logic [RATE_W-1:0]         cfg_rate,
  input  logic [N_CORES-1:0]        flit_ready,
  input  logic [N_CORES-1:0]        port_free,
  input  logic [N_CORES-1:0]        instr_ret,
  output logic [N_CORES-1:0]        inj_grant,
  output logic [N_CORES*RATE_W-1:0] rate_out,
  output logic                      congested
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam int TOT_W = CNT_W + $clog2(N_CORES) + 1;

  logic [CNT_W-1:0] timer;
  logic             tick;
  logic             cong_now;
  logic [N_CORES*RATE_W-1:0] rate_new;
  logic [N_CORES*RATE_W-1:0] rate_q;
  logic [N_CORES*CNT_W-1:0]  starve_q, instr_q, flit_q;
  logic [N_CORES*CNT_W-1:0]  starve_nxt, instr_nxt, flit_nxt;

  assign tick = (timer == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    timer <= '0;
    else if (tick) timer <= '0;
    else           timer <= timer + 1'b1;
  end

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    inj_thr_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (rate_q[g*RATE_W +: RATE_W]),
      .ready (flit_ready[g]),
      .free  (port_free[g]),
      .grant (inj_grant[g])
    );
    inj_thr_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (tick),
      .starve_ev  (flit_ready[g] & ~port_free[g]),
      .instr_ev   (instr_ret[g]),
      .flit_ev    (inj_grant[g]),
      .starve_q   (starve_q[g*CNT_W +: CNT_W]),
      .instr_q    (instr_q[g*CNT_W +: CNT_W]),
      .flit_q     (flit_q[g*CNT_W +: CNT_W]),
      .starve_nxt (starve_nxt[g*CNT_W +: CNT_W]),
      .instr_nxt  (instr_nxt[g*CNT_W +: CNT_W]),
      .flit_nxt   (flit_nxt[g*CNT_W +: CNT_W])
    );
  end

  inj_thr_decide #(
    .N_CORES (N_CORES),
    .CNT_W   (CNT_W),
    .TOT_W   (TOT_W),
    .FRAC_K  (FRAC_K),
    .INTERVAL(INTERVAL)
  ) u_decide (
    .starve  (starve_nxt),
    .instr   (instr_nxt),
    .flits   (flit_nxt),
    .thr     (cfg_starve_thr),
    .cfg_rate(cfg_rate),
    .cong    (cong_now),
    .rate_new(rate_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q    <= '0;
      congested <= 1'b0;
    end else if (tick) begin
      rate_q    <= rate_new;
      congested <= cong_now;
    end
  end

  assign rate_out = rate_q;
endmodule

// File: rtl/inj_thr_chk.sv
`timescale 1ns/1ps
module inj_thr_chk #(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 17,
  parameter int RATE_W  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic                      cong_now,
  input logic [N_CORES-1:0]        flit_ready,
  input logic [N_CORES-1:0]        port_free,
  input logic [N_CORES-1:0]        inj_grant,
  input logic [N_CORES*RATE_W-1:0] rate_out,
  input logic                      congested,
  input logic [N_CORES*CNT_W-1:0]  starve_q,
  input logic [N_CORES*CNT_W-1:0]  instr_q,
  input logic [N_CORES*CNT_W-1:0]  flit_q,
  input logic [N_CORES*CNT_W-1:0]  flit_nxt
);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(rate_out) && $stable(congested)));

  assert_calm_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cong_now) |=> (rate_out == '0));

  assert_rate_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_out != '0) |-> congested);

  assert_counters_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (starve_q == '0 && instr_q == '0 && flit_q == '0));

  for (genvar g = 0; g < N_CORES; g++) begin : g_chk
    assert_grant_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inj_grant[g] |-> (flit_ready[g] && port_free[g]));

    assert_open_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_out[g*RATE_W +: RATE_W] == '0) |-> (inj_grant[g] == (flit_ready[g] && port_free[g])));

    assert_idle_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && flit_nxt[g*CNT_W +: CNT_W] == '0) |=> (rate_out[g*RATE_W +: RATE_W] == '0));
  end
endmodule

bind inj_throttle_ctrl inj_thr_chk #(.N_CORES(N_CORES), .CNT_W(CNT_W), .RATE_W(4)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .cong_now  (cong_now),
  .flit_ready(flit_ready),
  .port_free (port_free),
  .inj_grant (inj_grant),
  .rate_out  (rate_out),
  .congested (congested),
  .starve_q  (starve_q),
  .instr_q   (instr_q),
  .flit_q    (flit_q),
  .flit_nxt  (flit_nxt)
);

// File: tb/inj_throttle_ctrl_bench.sv
`timescale 1ns/1ps
module inj_throttle_ctrl_bench;
  localparam int N  = 4;
  localparam int IV = 64;
  localparam int K  = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [K:0]     thr = 7'd16;
  logic [3:0]     cfg_rate = 4'd12;
  logic [N-1:0]   flit_ready = '0, port_free = '0, instr_ret = '0;
  logic [N-1:0]   inj_grant;
  logic [N*4-1:0] rate_out;
  logic           congested;

  int vectors = 0, fails = 0;
  bit done = 0;

  // Behavioural reference state
  int m_timer = 0, m_phase = 0, m_cong = 0;
  int m_rate[N], m_st[N], m_in[N], m_fl[N];
  string m_tag[N];
  int p_ready[N], p_free[N], p_ret[N];
  int det_cut = -1;

  always #5 clk = ~clk;

  inj_throttle_ctrl #(.N_CORES(N), .INTERVAL(IV), .FRAC_K(K)) u_inj_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_starve_thr(thr), .cfg_rate(cfg_rate),
    .flit_ready(flit_ready), .port_free(port_free), .instr_ret(instr_ret),
    .inj_grant(inj_grant), .rate_out(rate_out), .congested(congested)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  task automatic decide();
    longint ti = 0, tf = 0, own, avg;
    int c = 0;
    for (int i = 0; i < N; i++) begin
      ti += m_in[i]; tf += m_fl[i];
      if (longint'(m_st[i]) * (1 << K) > longint'(thr) * IV) c = 1;   // R1
    end
    m_cong = c;
    for (int i = 0; i < N; i++) begin
      own = longint'(m_in[i]) * tf;
      avg = ti * longint'(m_fl[i]);
      if (!c)                 begin m_rate[i] = 0;             m_tag[i] = "R3"; end
      else if (m_fl[i] == 0)  begin m_rate[i] = 0;             m_tag[i] = "R6"; end
      else if (2 * own < avg) begin m_rate[i] = cfg_rate;      m_tag[i] = "R4"; end
      else if (own < avg)     begin m_rate[i] = cfg_rate >> 1; m_tag[i] = "R5"; end
      else                    begin m_rate[i] = 0;             m_tag[i] = "R5"; end
      m_st[i] = 0; m_in[i] = 0; m_fl[i] = 0;   // R8: fresh counts each interval
    end
  endtask

  // One cycle: drive at the falling edge, compare, advance the model.
  task automatic step();
    int eg;
    for (int i = 0; i < N; i++) begin
      if (det_cut >= 0) begin
        flit_ready[i] = (i == 0);
        port_free[i]  = (i != 0) || (m_timer >= det_cut);
        instr_ret[i]  = 1'b0;
      end else begin
        flit_ready[i] = ($urandom_range(99) < p_ready[i]);
        port_free[i]  = ($urandom_range(99) < p_free[i]);
        instr_ret[i]  = ($urandom_range(99) < p_ret[i]);
      end
    end
    #1;
    chk("R1 congested", congested, m_cong);
    for (int i = 0; i < N; i++) begin
      eg = (flit_ready[i] && port_free[i] && !(m_phase < m_rate[i])) ? 1 : 0;
      chk("R7 grant", inj_grant[i], eg);
      chk({m_tag[i], " rate (R2 timing)"}, rate_out[i*4 +: 4], m_rate[i]);
      // R10: events counted from the ports
      if (flit_ready[i] && !port_free[i]) m_st[i]++;
      if (instr_ret[i]) m_in[i]++;
      if (eg) m_fl[i]++;
    end
    if (m_timer == IV - 1) begin decide(); m_timer = 0; end
    else m_timer++;
    m_phase = (m_phase + 1) % 16;
    @(negedge clk);
  endtask

  task automatic set_load(input int rdy, input int fr, input int r0, input int r1, input int r2);
    for (int i = 0; i < N; i++) begin p_ready[i] = rdy; p_free[i] = fr; end
    p_ready[3] = 0;          // core 3 never injects (R6)
    p_ret[0] = r0; p_ret[1] = r1; p_ret[2] = r2; p_ret[3] = 50;
  endtask

  task automatic run_interval();
    for (int c = 0; c < IV; c++) step();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_rate[i] = 0; m_st[i] = 0; m_in[i] = 0; m_fl[i] = 0; m_tag[i] = "R3";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset rates", rate_out, 0);
    chk("R9 reset flag", congested, 0);
    rst_n = 1'b1;

    set_load(50, 100, 50, 50, 50);   // calm: nothing starves
    run_interval();
    set_load(90, 30, 5, 40, 95);     // heavy starvation, uneven yield
    run_interval();
    run_interval();
    cfg_rate = 4'd9;                 // odd rate for the half tier
    set_load(90, 35, 15, 90, 30);
    run_interval();
    set_load(80, 100, 50, 50, 50);   // calm again: rates fall to zero
    run_interval();
    det_cut = 16;                    // core 0 starves exactly thr cycles
    run_interval();
    det_cut = 17;                    // one cycle over the limit
    run_interval();
    det_cut = -1;
    set_load(90, 25, 10, 60, 90);
    run_interval();
    run_interval();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule